// File: doc/BRIEF.md
# GPIO Port Controller

A sixteen-pin general-purpose I/O port controlled through 32-bit registers on a simple memory-mapped bus. Each pin has a two-bit mode field, an output type bit, a speed field, a pull field and an alternate-function selector. Software drives the pins in one of two ways. It can write the output data register, or it can use a write-only set/clear register that changes chosen output bits in one access.

Pin levels pass through a synchronizer and are captured every cycle into a read-only input register. Reads of that register show only the pins whose direction is input. The direction of each pin is held in its own register. A write to the mode field updates it: encoding 0 makes the pin an input, encoding 1 makes it an output, and the alternate and analog encodings leave it unchanged. An instance parameter selects the reset values of the configuration registers. The lock register is plain storage.

The bus is single-cycle. A request with `we_i` high writes on that clock edge. A request with `we_i` low returns its data on `rdata_o` in the following cycle.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero, with these exceptions. When PORT_ID is 0, mode is 0xA8000000 and pull is 0x64000000. When PORT_ID is 1, mode is 0x00000280, pull is 0x00000100 and speed is 0x000000C0. Reset direction is all outputs: `oe_o` = 0xFFFF, `pins_o` = 0, `err_o` = 0.
- R2: The following registers store a full 32-bit write and read it back unchanged: mode 0x00, output type 0x04, speed 0x08, pull 0x0C, lock 0x1C, alternate low 0x20 and alternate high 0x24. Two kinds of access are unmapped: 32-bit accesses to any other offset or to a non-multiple-of-4 offset, and 16-bit accesses anywhere except 0x1A. Unmapped accesses read zero and change nothing.
- R3: Pin n uses mode bits 2n+1:2n. A mode write with field 0 makes the pin an input and field 1 makes it an output. Fields 2 and 3 keep the pin's previous direction. The reset mode value does not set the direction.
- R4: A write to output data (0x14) stores bit n as data bit n when pin n is an output, and as 0 when pin n is an input.
- R5: A 32-bit write to set/clear (0x18) first clears each output bit n where data bit 16+n is 1, then sets each output bit n where data bit n is 1. When both bits are 1, set wins.
- R6: Set/clear always reads zero: as a 32-bit read at 0x18 and as a 16-bit read at 0x1A.
- R7: A 16-bit write at 0x1A clears output bit n wherever data bit n (of `wdata_i[15:0]`) is 1. Other output bits are unchanged.
- R8: A 32-bit write to input data (0x10) changes no register. It raises `err_o` for exactly the following cycle.
- R9: Reading input data (0x10) returns the pin levels in bits 15:0, ANDed with the input-direction mask, with bits 31:16 zero. The read reflects a pin change once three clock edges have passed after the change.
- R10: `pins_o` equals the output data register and `oe_o` is high for each pin whose direction is output. Both update on the clock edge of the write that changes them.
- R11: Read data appears on `rdata_o` in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| half_i | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data (16-bit data in bits 15:0) |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| err_o | output | 1 | One-cycle flag for a write to the input register |
| pins_i | input | 16 | Pin levels from the pads |
| pins_o | output | 16 | Pin output values |
| oe_o | output | 16 | Pin output enables, 1 = driven |

## Verification
A stale or wrong direction bit appears on `oe_o` at the clock edge right after the mode write. It also appears later as a wrongly masked input read or a wrongly masked output data write. A corrupted output bit reaches `pins_o` one edge after the access that caused it. The random sequences therefore compare both pin vectors after every write, alongside register read-back. A wrong synchronizer depth only shows up as stale input reads, so the bench waits exactly three edges after each pin change before reading.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [5:0] OFF_MODE   = 6'h00;
  localparam logic [5:0] OFF_OTYPE  = 6'h04;
  localparam logic [5:0] OFF_SPEED  = 6'h08;
  localparam logic [5:0] OFF_PULL   = 6'h0C;
  localparam logic [5:0] OFF_IDATA  = 6'h10;
  localparam logic [5:0] OFF_ODATA  = 6'h14;
  localparam logic [5:0] OFF_SETCLR = 6'h18;
  localparam logic [5:0] OFF_CLRHI  = 6'h1A;
  localparam logic [5:0] OFF_LOCK   = 6'h1C;
  localparam logic [5:0] OFF_AFLO   = 6'h20;
  localparam logic [5:0] OFF_AFHI   = 6'h24;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALT    = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic mode;
    logic otype;
    logic speed;
    logic pull;
    logic idata;
    logic odata;
    logic setclr;
    logic clrhi;
    logic lock;
    logic aflo;
    logic afhi;
  } reg_hit_t;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] speed;
    logic [31:0] pull;
  } cfg_rst_t;

  function automatic cfg_rst_t cfg_reset(input int port_id);
    cfg_rst_t r;
    r = '0;
    case (port_id)
      0: begin
        r.mode = 32'hA800_0000;
        r.pull = 32'h6400_0000;
      end
      1: begin
        r.mode  = 32'h0000_0280;
        r.pull  = 32'h0000_0100;
        r.speed = 32'h0000_00C0;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  output reg_hit_t          hit_o
);

  always_comb begin
    hit_o = '0;
    if (half_i) begin
      hit_o.clrhi = (addr_i == ADDR_W'(OFF_CLRHI));
    end else if (addr_i[1:0] == 2'b00) begin
      hit_o.mode   = (addr_i == ADDR_W'(OFF_MODE));
      hit_o.otype  = (addr_i == ADDR_W'(OFF_OTYPE));
      hit_o.speed  = (addr_i == ADDR_W'(OFF_SPEED));
      hit_o.pull   = (addr_i == ADDR_W'(OFF_PULL));
      hit_o.idata  = (addr_i == ADDR_W'(OFF_IDATA));
      hit_o.odata  = (addr_i == ADDR_W'(OFF_ODATA));
      hit_o.setclr = (addr_i == ADDR_W'(OFF_SETCLR));
      hit_o.lock   = (addr_i == ADDR_W'(OFF_LOCK));
      hit_o.aflo   = (addr_i == ADDR_W'(OFF_AFLO));
      hit_o.afhi   = (addr_i == ADDR_W'(OFF_AFHI));
    end
  end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter cfg_rst_t    RST   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_hit_t         wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mode_o,
  output logic [REG_W-1:0] otype_o,
  output logic [REG_W-1:0] speed_o,
  output logic [REG_W-1:0] pull_o,
  output logic [REG_W-1:0] lock_o,
  output logic [REG_W-1:0] aflo_o,
  output logic [REG_W-1:0] afhi_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= RST.mode[REG_W-1:0];
      otype_o <= '0;
      speed_o <= RST.speed[REG_W-1:0];
      pull_o  <= RST.pull[REG_W-1:0];
      lock_o  <= '0;
      aflo_o  <= '0;
      afhi_o  <= '0;
    end else begin
      if (wr_i.mode)  mode_o  <= wdata_i;
      if (wr_i.otype) otype_o <= wdata_i;
      if (wr_i.speed) speed_o <= wdata_i;
      if (wr_i.pull)  pull_o  <= wdata_i;
      if (wr_i.lock)  lock_o  <= wdata_i;
      if (wr_i.aflo)  aflo_o  <= wdata_i;
      if (wr_i.afhi)  afhi_o  <= wdata_i;
    end
  end

endmodule

// File: rtl/gpio_dir_track.sv
module gpio_dir_track
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [2*NPINS-1:0] mode_i,
  output logic [NPINS-1:0]   dir_o     // 1 = input
);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    pin_mode_e fld;
    assign fld = pin_mode_e'(mode_i[2*n +: 2]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_o[n] <= 1'b0;
      end else if (wr_i) begin
        if (fld == PM_INPUT)       dir_o[n] <= 1'b1;
        else if (fld == PM_OUTPUT) dir_o[n] <= 1'b0;
      end
    end

    assert_dir_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mode_i[2*n +: 2] == 2'd0) |=> dir_o[n]);
    assert_dir_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mode_i[2*n +: 2] == 2'd1) |=> !dir_o[n]);
    assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mode_i[2*n+1]) |=> $stable(dir_o[n]));
  end

endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_data_i,
  input  logic               wr_setclr_i,
  input  logic               wr_clrhi_i,
  input  logic [2*NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0]   dir_i,
  output logic [NPINS-1:0]   odata_o
);

  logic [NPINS-1:0] set_v, clr_v;
  assign set_v = wdata_i[NPINS-1:0];
  assign clr_v = wdata_i[2*NPINS-1:NPINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odata_o <= '0;
    end else if (wr_data_i) begin
      odata_o <= set_v & ~dir_i;
    end else if (wr_setclr_i) begin
      odata_o <= (odata_o & ~clr_v) | set_v;   // clear then set
    end else if (wr_clrhi_i) begin
      odata_o <= odata_o & ~set_v;             // 16-bit data lands in low half
    end
  end

  assert_odata_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> ((odata_o & dir_i) == '0));
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr_i |=> ((odata_o & $past(set_v)) == $past(set_v)));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr_i |=> ((odata_o & $past(clr_v & ~set_v)) == '0));
  assert_half_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clrhi_i |=> ((odata_o & $past(set_v)) == '0));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] idata_o
);

  logic [STAGES-1:0][NPINS-1:0] sreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg    <= '0;
      idata_o <= '0;
    end else begin
      sreg[0] <= pins_i;
      for (int s = 1; s < STAGES; s++) sreg[s] <= sreg[s-1];
      idata_o <= sreg[STAGES-1];
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int          PORT_ID     = 0,
  parameter int unsigned NPINS       = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 half_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2*NPINS-1:0]   wdata_i,
  output logic [2*NPINS-1:0]   rdata_o,
  output logic                 err_o,
  input  logic [NPINS-1:0]     pins_i,
  output logic [NPINS-1:0]     pins_o,
  output logic [NPINS-1:0]     oe_o
);

  localparam int unsigned REG_W = 2 * NPINS;
  localparam cfg_rst_t    RST   = cfg_reset(PORT_ID);

  reg_hit_t         hit, wr;
  logic [REG_W-1:0] mode_q, otype_q, speed_q, pull_q, lock_q, aflo_q, afhi_q;
  logic [NPINS-1:0] dir_q, odata_q, idata_q;
  logic [REG_W-1:0] rd_val;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .half_i (half_i),
    .hit_o  (hit)
  );

  assign wr = (req_i && we_i) ? hit : '0;

  gpio_cfg_regs #(.REG_W(REG_W), .RST(RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .wdata_i (wdata_i),
    .mode_o  (mode_q),
    .otype_o (otype_q),
    .speed_o (speed_q),
    .pull_o  (pull_q),
    .lock_o  (lock_q),
    .aflo_o  (aflo_q),
    .afhi_o  (afhi_q)
  );

  gpio_dir_track #(.NPINS(NPINS)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr.mode),
    .mode_i (wdata_i),
    .dir_o  (dir_q)
  );

  gpio_out_ctrl #(.NPINS(NPINS)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_data_i   (wr.odata),
    .wr_setclr_i (wr.setclr),
    .wr_clrhi_i  (wr.clrhi),
    .wdata_i     (wdata_i),
    .dir_i       (dir_q),
    .odata_o     (odata_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins_i),
    .idata_o (idata_q)
  );

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      hit.mode:  rd_val = mode_q;
      hit.otype: rd_val = otype_q;
      hit.speed: rd_val = speed_q;
      hit.pull:  rd_val = pull_q;
      hit.idata: rd_val = {{NPINS{1'b0}}, idata_q & dir_q};
      hit.odata: rd_val = {{NPINS{1'b0}}, odata_q};
      hit.lock:  rd_val = lock_q;
      hit.aflo:  rd_val = aflo_q;
      hit.afhi:  rd_val = afhi_q;
      default:   rd_val = '0;   // set/clear, unmapped
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_o <= rd_val;
      err_o <= wr.idata;
    end
  end

  assign pins_o = odata_q;
  assign oe_o   = ~dir_q;

  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && we_i && !half_i && addr_i == ADDR_W'(OFF_IDATA)));
  assert_setclr_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (hit.setclr || hit.clrhi)) |=> (rdata_o == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_idata_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.idata |=> ($stable(odata_q) && $stable(dir_q) && $stable(mode_q)));
  assert_hit_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, half = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pins = '0;
  logic [31:0] rdata, rdata_b;
  logic        err, err_b;
  logic [15:0] pins_o, oe, pins_o_b, oe_b;

  int n_chk = 0;
  int n_err = 0;

  // model
  logic [31:0] m_mode, m_otype, m_speed, m_pull, m_lock, m_aflo, m_afhi;
  logic [15:0] m_dir, m_odata;

  always #4 clk = ~clk;   // 125 MHz

  gpio_port #(.PORT_ID(0)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .half_i(half),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .pins_i(pins), .pins_o(pins_o), .oe_o(oe)
  );

  gpio_port #(.PORT_ID(1)) u_gpio_port_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .half_i(half),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b), .err_o(err_b),
    .pins_i(pins), .pins_o(pins_o_b), .oe_o(oe_b)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %08h exp %08h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] next_dir(input logic [15:0] d, input logic [31:0] mode);
    logic [15:0] r = d;
    for (int n = 0; n < 16; n++) begin
      if (mode[2*n +: 2] == 2'd0) r[n] = 1'b1;
      else if (mode[2*n +: 2] == 2'd1) r[n] = 1'b0;
    end
    return r;
  endfunction

  task automatic m_write(input logic [5:0] a, input logic h, input logic [31:0] d);
    if (h) begin
      if (a == 6'h1A) m_odata = m_odata & ~d[15:0];
    end else if (a[1:0] == 2'b00) begin
      case (a)
        6'h00: begin m_mode = d; m_dir = next_dir(m_dir, d); end
        6'h04: m_otype = d;
        6'h08: m_speed = d;
        6'h0C: m_pull = d;
        6'h14: m_odata = d[15:0] & ~m_dir;
        6'h18: m_odata = (m_odata & ~d[31:16]) | d[15:0];
        6'h1C: m_lock = d;
        6'h20: m_aflo = d;
        6'h24: m_afhi = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] a, input logic h);
    if (h || a[1:0] != 2'b00) return 32'h0;
    case (a)
      6'h00: return m_mode;
      6'h04: return m_otype;
      6'h08: return m_speed;
      6'h0C: return m_pull;
      6'h10: return {16'h0, pins & m_dir};
      6'h14: return {16'h0, m_odata};
      6'h1C: return m_lock;
      6'h20: return m_aflo;
      6'h24: return m_afhi;
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_wr(input logic [5:0] a, input logic h, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; half = h; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; half = 1'b0;
    m_write(a, h, d);
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic h, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; half = h; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0; half = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic h);
    logic [31:0] d;
    bus_rd(a, h, d);
    chk(tag, d, m_read(a, h));
  endtask

  task automatic pins_chk(input string tag);
    chk({tag, " pins_o"}, {16'h0, pins_o}, {16'h0, m_odata});
    chk({tag, " oe_o"}, {16'h0, oe}, {16'h0, ~m_dir});
  endtask

  task automatic set_pins(input logic [15:0] p);
    @(negedge clk);
    pins = p;
    repeat (3) @(posedge clk);
  endtask

  task automatic all_regs_chk(input string tag);
    rd_chk({tag, " mode"},  6'h00, 1'b0);
    rd_chk({tag, " otype"}, 6'h04, 1'b0);
    rd_chk({tag, " speed"}, 6'h08, 1'b0);
    rd_chk({tag, " pull"},  6'h0C, 1'b0);
    rd_chk({tag, " odata"}, 6'h14, 1'b0);
    rd_chk({tag, " lock"},  6'h1C, 1'b0);
    rd_chk({tag, " aflo"},  6'h20, 1'b0);
    rd_chk({tag, " afhi"},  6'h24, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [5:0] offs [13];
    void'($urandom(32'h5EED_0042));
    offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1A,
             6'h1C, 6'h20, 6'h24, 6'h28, 6'h3C};
    m_mode = 32'hA800_0000; m_pull = 32'h6400_0000; m_speed = '0;
    m_otype = '0; m_lock = '0; m_aflo = '0; m_afhi = '0;
    m_dir = '0; m_odata = '0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 err in reset", {31'h0, err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    pins_chk("R1 reset");
    all_regs_chk("R1 reset A");
    rd_chk("R1 reset idata", 6'h10, 1'b0);
    bus_rd(6'h00, 1'b0, d); chk("R1 reset B mode",  rdata_b, 32'h0000_0280);
    bus_rd(6'h0C, 1'b0, d); chk("R1 reset B pull",  rdata_b, 32'h0000_0100);
    bus_rd(6'h08, 1'b0, d); chk("R1 reset B speed", rdata_b, 32'h0000_00C0);
    chk("R1 reset B oe", {16'h0, oe_b}, 32'h0000_FFFF);

    // R2 storage
    bus_wr(6'h04, 1'b0, 32'hDEAD_BEEF);
    bus_wr(6'h08, 1'b0, 32'h1234_5678);
    bus_wr(6'h0C, 1'b0, 32'hFFFF_0000);
    bus_wr(6'h1C, 1'b0, 32'h0001_8001);
    bus_wr(6'h20, 1'b0, 32'hCAFE_F00D);
    bus_wr(6'h24, 1'b0, 32'h0BAD_C0DE);
    all_regs_chk("R2 storage");
    // R2 unmapped
    bus_wr(6'h28, 1'b0, 32'hFFFF_FFFF);
    bus_wr(6'h02, 1'b0, 32'hFFFF_FFFF);
    bus_wr(6'h04, 1'b1, 32'h0000_FFFF);
    bus_wr(6'h3C, 1'b0, 32'hFFFF_FFFF);
    all_regs_chk("R2 unmapped write");
    pins_chk("R2 unmapped write");
    rd_chk("R2 unmapped read 0x28", 6'h28, 1'b0);
    rd_chk("R2 misaligned read 0x06", 6'h06, 1'b0);

    // R3 direction from mode
    bus_wr(6'h00, 1'b0, 32'h0000_0000); pins_chk("R3 all input");
    bus_wr(6'h00, 1'b0, 32'hAAAA_AAAA); pins_chk("R3 alt keeps");
    bus_wr(6'h00, 1'b0, 32'h5555_5555); pins_chk("R3 all output");
    bus_wr(6'h00, 1'b0, 32'hFFFF_FFFF); pins_chk("R3 analog keeps");
    bus_wr(6'h00, 1'b0, 32'h1E4B_0D60); pins_chk("R3 mixed");
    rd_chk("R3 mode readback", 6'h00, 1'b0);

    // R4 output data masking
    bus_wr(6'h00, 1'b0, 32'h5555_0000);   // high pins out, low pins in
    bus_wr(6'h14, 1'b0, 32'hFFFF_FFFF);
    pins_chk("R4 masked");
    rd_chk("R4 odata", 6'h14, 1'b0);
    chk("R4 pins_o", {16'h0, pins_o}, 32'h0000_FF00);

    // R5 set/clear, set wins
    bus_wr(6'h00, 1'b0, 32'h5555_5555);
    bus_wr(6'h14, 1'b0, 32'h0000_F0F0);
    bus_wr(6'h18, 1'b0, 32'hFF00_0F0F);
    pins_chk("R5 setclr");
    chk("R5 set wins", {16'h0, pins_o}, 32'h0000_0FFF);
    rd_chk("R6 setclr reads zero", 6'h18, 1'b0);
    rd_chk("R6 half 0x1A reads zero", 6'h1A, 1'b1);

    // R7 half clear
    bus_wr(6'h1A, 1'b1, 32'h0000_0303);
    pins_chk("R7 half clear");
    chk("R7 pins_o", {16'h0, pins_o}, 32'h0000_0CFC);

    // R8 input write ignored, err pulse
    bus_wr(6'h10, 1'b0, 32'hFFFF_FFFF);
    chk("R8 err pulse", {31'h0, err}, 32'h1);
    @(negedge clk);
    chk("R8 err one cycle", {31'h0, err}, 32'h0);
    pins_chk("R8 ignored");
    all_regs_chk("R8 ignored");

    // R9 input sampling and masking
    bus_wr(6'h00, 1'b0, 32'h0000_5555);   // low out, high in
    set_pins(16'hA5C3);
    rd_chk("R9 masked input", 6'h10, 1'b0);
    set_pins(16'h3C5A);
    rd_chk("R9 input after change", 6'h10, 1'b0);

    // R11 read data holds
    bus_rd(6'h24, 1'b0, d);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, m_afhi);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [5:0] a;
      logic h;
      logic [31:0] v;
      if ($urandom_range(0, 3) == 0) set_pins(16'($urandom));
      a = offs[$urandom_range(0, 12)];
      h = (a == 6'h1A) ? 1'b1 : ($urandom_range(0, 9) == 0);
      v = $urandom;
      if ($urandom_range(0, 3) == 0) v[31:16] = v[15:0];   // set and clear together
      bus_wr(a, h, v);
      chk("R8 random err", {31'h0, err}, {31'h0, (a == 6'h10 && !h)});
      pins_chk("R10 random");
      a = offs[$urandom_range(0, 12)];
      h = (a == 6'h1A) ? 1'b1 : ($urandom_range(0, 9) == 0);
      rd_chk("R2 random read", a, h);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule